// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a way into a small bank of chipset-style configuration registers through two I/O addresses. The host writes an 8-bit register number to the index port. Later reads and writes on the paired data port then reach the register named by that number. The block decodes the I/O address and keeps the current index. It stores the writable fields and puts together the read value from three sources: the stored fields, status and strap inputs, and fixed constants.

Some bits cannot be changed by software. The status bits of the chip-control register come straight from input pins. The chip and revision registers are constants combined with revision inputs. Two bits of the clock register always read as fixed values. One bit of the chip-control register moves the whole port pair to an alternate address. The register contents are also driven out flat, so that the downstream logic they control can use them.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index reads 0x00 and the ports sit at 0xA8 (index) and 0xA9 (data). Register 0 reads {status,3'b000}, register 1 reads {rom_wide,7'h20}, register 2 reads 0x05, and register 5 reads 0x10.
- R2: A write to the index port loads the index. A read of the index port returns it. Data-port reads and writes reach the register the index names.
- R3: When bit 0 of register 0 is 1, the ports are at 0xA2 (index) and 0xA3 (data), and the default pair no longer responds. Writing 0 to that bit moves the ports back to 0xA8/0xA9.
- R4: The address change applies from the access after the one that writes bit 0. That data write itself is decoded at the old address.
- R5: Bits 7:3 of register 0 always show `status_in[4:0]`, and writes to them have no effect. Bits 2:0 are writable.
- R6: Register 3 reads {4'h0, rev_core}, and register 4 reads {4'h1, rev_bus}. Writes to either register have no effect.
- R7: Register 2 bit 1 always reads 0 and bit 0 always reads 1. Bits 7:2 are writable.
- R8: Register 1 bit 7 shows `rom_wide`. Bits 4:0 are writable. Bits 6:5 are writable, except that a write carrying 2'b00 in that field leaves the previous field value in place.
- R9: Register 5 bits 7:4 are writable, and bits 3:0 read 0.
- R10: Indices 6 to 255 read 0xFF, and writes to them change no register.
- R11: A read at an address outside the current pair gives `rd_hit`=0 and `io_rdata`=0x00. A write there changes neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational, 0 when no hit) |
| rd_hit | output | 1 | Read addresses the index or data port |
| status_in | input | 5 | Status straps shown in register 0 bits 7:3 |
| rom_wide | input | 1 | Strap shown in register 1 bit 7 |
| rev_core | input | 4 | Revision nibble of register 3 |
| rev_bus | input | 4 | Revision nibble of register 4 |
| cfg_out | output | 48 | Stored register bytes, register n at bits 8n+7:8n |

## Verification
The hardest state to reach is the relocation window. It needs a data write to index 0 that sets bit 0, followed at once by accesses at both the old and the new pair, and then a clearing write at the new pair. The bench walks through exactly that sequence and checks that the old pair goes silent. It also sweeps all 256 indices with several data patterns against a bench-side model, masking bit 0 of register 0 so that the sweep never relocates the ports. A full 256-address read sweep confirms that only the current pair responds.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int DW   = 8;
    localparam int NREG = 6;

    localparam int IX_CHIP = 0;
    localparam int IX_ROM  = 1;
    localparam int IX_CLK  = 2;
    localparam int IX_IDA  = 3;
    localparam int IX_IDB  = 4;
    localparam int IX_DMA  = 5;

    typedef logic [NREG-1:0][DW-1:0] reg_bank_t;

    typedef struct packed {
        logic [DW-1:0] idx;
        reg_bank_t     regs;
    } cfg_state_t;

    function automatic logic [DW-1:0] wr_mask(input int i);
        case (i)
            IX_CHIP: return 8'h07;
            IX_ROM:  return 8'h7F;
            IX_CLK:  return 8'hFC;
            IX_DMA:  return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] rst_byte(input int i);
        case (i)
            IX_ROM:  return 8'h20;
            IX_CLK:  return 8'h04;
            IX_DMA:  return 8'h10;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] BASE_DEF = 'hA8,
    parameter logic [ADDR_W-1:0] BASE_ALT = 'hA2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              alt,
    output logic              hit_idx,
    output logic              hit_dat
);
    localparam logic [ADDR_W-1:0] DAT_DEF = BASE_DEF + 1'b1;
    localparam logic [ADDR_W-1:0] DAT_ALT = BASE_ALT + 1'b1;

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;

    always_comb begin
        idx_addr = alt ? BASE_ALT : BASE_DEF;
        dat_addr = alt ? DAT_ALT  : DAT_DEF;
        hit_idx  = (addr == idx_addr);
        hit_dat  = (addr == dat_addr);
    end
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_idx,
    input  logic          wr_dat,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] idx_q,
    output reg_bank_t     regs_q
);
    cfg_state_t state_d, state_q;
    cfg_state_t state_rst;

    always_comb begin
        state_rst.idx = '0;
        for (int i = 0; i < NREG; i++) begin
            state_rst.regs[i] = rst_byte(i);
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_idx) begin
            state_d.idx = wdata;
        end else if (wr_dat) begin
            for (int i = 0; i < NREG; i++) begin
                if (state_q.idx == DW'(i)) begin
                    state_d.regs[i] = (wdata & wr_mask(i)) |
                                      (state_q.regs[i] & ~wr_mask(i));
                    if (i == IX_ROM && wdata[6:5] == 2'b00) begin
                        state_d.regs[i][6:5] = state_q.regs[i][6:5];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= state_rst;
        else        state_q <= state_d;
    end

    assign idx_q  = state_q.idx;
    assign regs_q = state_q.regs;
endmodule

// File: rtl/cfgport_rdmux.sv
module cfgport_rdmux
    import cfgport_pkg::*;
(
    input  logic [DW-1:0] idx,
    input  reg_bank_t     regs,
    input  logic          hit_idx,
    input  logic          hit_dat,
    input  logic [4:0]    status_in,
    input  logic          rom_wide,
    input  logic [3:0]    rev_core,
    input  logic [3:0]    rev_bus,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] reg_val;

    always_comb begin
        case (idx)
            DW'(IX_CHIP): reg_val = {status_in, regs[IX_CHIP][2:0]};
            DW'(IX_ROM):  reg_val = {rom_wide, regs[IX_ROM][6:0]};
            DW'(IX_CLK):  reg_val = {regs[IX_CLK][7:2], 2'b01};
            DW'(IX_IDA):  reg_val = {4'h0, rev_core};
            DW'(IX_IDB):  reg_val = {4'h1, rev_bus};
            DW'(IX_DMA):  reg_val = {regs[IX_DMA][7:4], 4'h0};
            default:      reg_val = 8'hFF;
        endcase
        if (hit_idx)      rdata = idx;
        else if (hit_dat) rdata = reg_val;
        else              rdata = '0;
    end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] BASE_DEF = 'hA8,
    parameter logic [ADDR_W-1:0] BASE_ALT = 'hA2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 rd_hit,
    input  logic [4:0]           status_in,
    input  logic                 rom_wide,
    input  logic [3:0]           rev_core,
    input  logic [3:0]           rev_bus,
    output logic [NREG*DW-1:0]   cfg_out
);
    logic [DW-1:0] idx_q;
    reg_bank_t     regs_q;
    logic          alt_q;
    logic          hit_idx, hit_dat;
    logic [DW-1:0] mux_data;

    assign alt_q = regs_q[IX_CHIP][0];

    cfgport_decode #(
        .ADDR_W(ADDR_W), .BASE_DEF(BASE_DEF), .BASE_ALT(BASE_ALT)
    ) u_decode (
        .addr(io_addr), .alt(alt_q), .hit_idx(hit_idx), .hit_dat(hit_dat)
    );

    cfgport_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_idx(io_wr && hit_idx), .wr_dat(io_wr && hit_dat),
        .wdata(io_wdata), .idx_q(idx_q), .regs_q(regs_q)
    );

    cfgport_rdmux u_rdmux (
        .idx(idx_q), .regs(regs_q), .hit_idx(hit_idx), .hit_dat(hit_dat),
        .status_in(status_in), .rom_wide(rom_wide),
        .rev_core(rev_core), .rev_bus(rev_bus), .rdata(mux_data)
    );

    assign rd_hit   = io_rd && (hit_idx || hit_dat);
    assign io_rdata = io_rd ? mux_data : '0;
    assign cfg_out  = regs_q;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] BASE_DEF = 'hA8,
    parameter logic [ADDR_W-1:0] BASE_ALT = 'hA2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              rd_hit,
    input logic [4:0]        status_in,
    input logic [7:0]        idx_q,
    input logic              alt_q
);
    logic [ADDR_W-1:0] cur_idx, cur_dat;
    logic              at_idx, at_dat;
    assign cur_idx = alt_q ? BASE_ALT : BASE_DEF;
    assign cur_dat = cur_idx + 1'b1;
    assign at_idx  = (io_addr == cur_idx);
    assign at_dat  = (io_addr == cur_dat);

    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_idx) |=> (idx_q == $past(io_wdata)));

    assert_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_dat && idx_q == 8'd0) |=> (alt_q == $past(io_wdata[0])));

    assert_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_dat && idx_q == 8'd0) |-> (io_rdata[7:3] == status_in));

    assert_ids_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_dat && (idx_q == 8'd3 || idx_q == 8'd4))
        |-> (io_rdata[7:4] == {3'b000, idx_q == 8'd4}));

    assert_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_dat && idx_q == 8'd2) |-> (io_rdata[1:0] == 2'b01));

    assert_unimpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_dat && idx_q > 8'd5) |-> (io_rdata == 8'hFF));

    assert_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !at_idx && !at_dat) |-> (!rd_hit && io_rdata == 8'h00));
endmodule

bind cfg_index_port cfg_index_port_chk #(
    .ADDR_W(ADDR_W), .BASE_DEF(BASE_DEF), .BASE_ALT(BASE_ALT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .rd_hit(rd_hit),
    .status_in(status_in), .idx_q(idx_q), .alt_q(alt_q)
);

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        rd_hit;
    logic [4:0]  status_in = 5'b10110;
    logic        rom_wide = 1'b1;
    logic [3:0]  rev_core = 4'h7;
    logic [3:0]  rev_bus = 4'hC;
    logic [47:0] cfg_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m0, m1, m2, m5;
    logic [7:0] got;
    logic       got_hit;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .rd_hit(rd_hit), .status_in(status_in), .rom_wide(rom_wide),
        .rev_core(rev_core), .rev_bus(rev_bus), .cfg_out(cfg_out)
    );

    function automatic logic [7:0] exp_reg(input logic [7:0] i);
        case (i)
            8'd0: return {status_in, m0[2:0]};
            8'd1: return {rom_wide, m1[6:0]};
            8'd2: return {m2[7:2], 2'b01};
            8'd3: return {4'h0, rev_core};
            8'd4: return {4'h1, rev_bus};
            8'd5: return {m5[7:4], 4'h0};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] i, input logic [7:0] d);
        case (i)
            8'd0: m0 = d & 8'h07;
            8'd1: m1 = {1'b0, (d[6:5] == 2'b00) ? m1[6:5] : d[6:5], d[4:0]};
            8'd2: m2 = d & 8'hFC;
            8'd5: m5 = d & 8'hF0;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        got = io_rdata; got_hit = rd_hit;
        @(posedge clk);
        #1;
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        m0 = 8'h00; m1 = 8'h20; m2 = 8'h04; m5 = 8'h10;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        io_read(8'hA8);
        chk("R1 index", got, 8'h00);
        for (int i = 0; i < 6; i++) begin
            io_write(8'hA8, 8'(i));
            io_read(8'hA9);
            chk("R1 default", got, exp_reg(8'(i)));
        end

        // R2, R5..R10 sweep of every index with several patterns
        for (int i = 0; i < 256; i++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] d;
                d = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h5A;
                if (i == 0) d = d & 8'hFE;
                io_write(8'hA8, 8'(i));
                io_read(8'hA8);
                chk("R2 index readback", got, 8'(i));
                io_write(8'hA9, d);
                model_wr(8'(i), d);
                io_read(8'hA9);
                chk((i > 5) ? "R10 unimpl" : (i == 0) ? "R5 status" :
                    (i == 1) ? "R8 rom" : (i == 2) ? "R7 forced" :
                    (i == 5) ? "R9 dma" : "R6 id", got, exp_reg(8'(i)));
            end
        end
        // R10 writes to unimplemented indices left the bank intact
        for (int i = 0; i < 6; i++) begin
            io_write(8'hA8, 8'(i));
            io_read(8'hA9);
            chk("R10 bank intact", got, exp_reg(8'(i)));
        end

        // R8 reserved 00 keeps old wait field
        io_write(8'hA8, 8'd1);
        io_write(8'hA9, 8'h40); model_wr(8'd1, 8'h40);
        io_write(8'hA9, 8'h03); model_wr(8'd1, 8'h03);
        io_read(8'hA9);
        chk("R8 keep field", got, 8'hC3);

        // R5 status follows input
        status_in = 5'b01001;
        io_write(8'hA8, 8'd0);
        io_write(8'hA9, 8'hF8); model_wr(8'd0, 8'hF8);
        io_read(8'hA9);
        chk("R5 live status", got, {5'b01001, 3'b000});

        // R11 full address sweep at default pair
        for (int a = 0; a < 256; a++) begin
            io_read(8'(a));
            chk("R11 hit", {7'b0, got_hit}, {7'b0, (a == 8'hA8) || (a == 8'hA9)});
            if (a != 8'hA8 && a != 8'hA9) chk("R11 zero", got, 8'h00);
        end
        io_write(8'h50, 8'h03);
        io_read(8'hA8);
        chk("R11 write ignored", got, 8'h00);

        // R3/R4 relocation
        io_write(8'hA9, 8'h01); model_wr(8'd0, 8'h01);
        io_read(8'hA9);
        chk("R4 old data silent", got, 8'h00);
        chk("R3 old miss", {7'b0, got_hit}, 8'h00);
        io_read(8'hA3);
        chk("R3 alt data", got, exp_reg(8'd0));
        io_write(8'hA8, 8'd2);
        io_read(8'hA2);
        chk("R3 old index ignored", got, 8'h00);
        io_write(8'hA2, 8'd5);
        io_read(8'hA2);
        chk("R3 alt index", got, 8'h05);
        io_write(8'hA3, 8'h70); model_wr(8'd5, 8'h70);
        io_read(8'hA3);
        chk("R3 alt data write", got, 8'h70);
        io_write(8'hA2, 8'd0);
        io_write(8'hA3, 8'h02); model_wr(8'd0, 8'h02);
        io_read(8'hA3);
        chk("R4 alt now silent", got, 8'h00);
        io_read(8'hA9);
        chk("R3 back to default", got, exp_reg(8'd0));
        chk("R3 cfg_out byte0", cfg_out[7:0], 8'h02);

        finish_run();
    end
endmodule